// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fill Engine

This engine fetches one cache block of four words from a main memory split into independently addressed banks. Word i of the block lives in bank i, because the two low bits of the word address select the bank. After a fill is accepted, the engine issues one request per cycle to successive banks, so their fixed access latencies run side by side rather than one after another. The data comes back over a single return bus that is one word wide. Words arrive in bank order, one per cycle, and the engine writes each into its slot of a block buffer.

The cost of one bank access is one cycle to send the address, fifteen cycles of bank latency and one cycle to return the word. With the accesses overlapped, a four-word fill takes twenty cycles. A build parameter selects a serial mode for comparison. In that mode each request waits until the previous word has returned, and the fill takes sixty-eight cycles. Cycle 0 is the first cycle after the accepting clock edge. The completion pulse comes in the cycle after the last word is written.

Top module: `fill_engine`

## Requirements
- R1: While reset is held and after its release, before any fill, `fill_done`, `bank_req` and `blk_data` are all zero.
- R2: A fill is accepted on a clock edge where `fill_req` is high and no fill is running. Every request carries `bank_addr = {fill_blk, b}`, where b is the two-bit index of the bank being asked. Bank b is the bit `bank_req[b]`, and it supplies word b.
- R3: In overlapped mode (SERIAL=0), `bank_req` is exactly one-hot with bit k in cycle k for k = 0..3, and zero in every other cycle of the fill.
- R4: The n-th `ret_valid` cycle of a fill writes `ret_data` into `blk_data[n*32 +: 32]`, counting n from 0. After completion the buffer holds the four words until the next fill writes them.
- R5: In overlapped mode `fill_done` is high in cycle 20 after acceptance (1 + 15 + 4).
- R6: In serial mode (SERIAL=1), bank k is requested in cycle 17k, which is the cycle after word k-1 returned, and `fill_done` is high in cycle 68.
- R7: `fill_done` is a one-cycle pulse. A new fill may be accepted in that same cycle.
- R8: `fill_req` raised while a fill is running is ignored. It adds no requests, and it changes neither the addresses nor the completion timing of the running fill.
- R9: `ret_valid` while no fill is running is ignored, and `blk_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_req | input | 1 | Start a block fill |
| fill_blk | input | ADDR_W-2 | Block address (word address without bank bits) |
| bank_req | output | NUM_BANKS | One request line per bank |
| bank_addr | output | ADDR_W | Word address sent with a request |
| ret_valid | input | 1 | Shared return bus carries a word |
| ret_data | input | DATA_W | Shared return bus word |
| blk_data | output | NUM_BANKS*DATA_W | Block buffer, word i at bits i*DATA_W |
| fill_done | output | 1 | Pulse in the cycle after the last word is stored |

## Verification
The bench builds two copies side by side, both with four banks, 32-bit words, a 16-bit word address and a 15-cycle bank latency. Instance u0 uses the overlapped schedule and u1 the serial one. The same fill pattern runs on both, so the 20-cycle and 68-cycle completion points and both request cadences are checked cycle by cycle in a single run. The pattern includes a fill accepted in the done cycle, a request made during a fill, and stray return strobes while idle. It also uses block addresses at all-zeros and all-ones.

// File: rtl/fill_pkg.sv
package fill_pkg;
  // One cycle to send, lat cycles in the bank, one cycle on the return bus.
  function automatic int fill_cycles(input int nb, input int lat, input bit serial);
    if (serial) return nb * (lat + 2);
    return nb + lat + 1;
  endfunction
endpackage

// File: rtl/fill_ctrl.sv
module fill_ctrl #(
  parameter int NB     = 4,
  parameter int BLK_W  = 14,
  parameter int LAT    = 15,
  parameter bit SERIAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_req,
  input  logic [BLK_W-1:0] fill_blk,
  input  logic             last_cap,
  output logic             busy,
  output logic             start,
  output logic [BLK_W-1:0] blk,
  output logic             done
);
  localparam int FILL  = fill_pkg::fill_cycles(NB, LAT, SERIAL);
  localparam int CYC_W = $clog2(FILL + 1);

  logic             busy_q, busy_d;
  logic [BLK_W-1:0] blk_q;
  logic             done_q, done_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             cyc_en;

  assign start = fill_req & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    if (start)         busy_d = 1'b1;
    else if (last_cap) busy_d = 1'b0;
    done_d = last_cap;
    cyc_en = start | busy_q;
    cyc_d  = start ? '0 : cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     blk_q <= '0;
    else if (start) blk_q <= fill_blk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (cyc_en) cyc_q <= cyc_d;
  end

  assign busy = busy_q;
  assign blk  = blk_q;
  assign done = done_q;

  // R5 / R6: completion lands at the schedule's cycle count
  a_r5_fill_span: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(cyc_q) == CYC_W'(FILL - 1));
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: a request during a fill leaves the latched block address alone
  a_r8_hold_blk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fill_req) |=> $stable(blk_q));
endmodule

// File: rtl/fill_issue.sv
module fill_issue #(
  parameter int NB     = 4,
  parameter int BLK_W  = 14,
  parameter int ADDR_W = 16,
  parameter bit SERIAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              start,
  input  logic [BLK_W-1:0]  blk,
  input  logic [$clog2(NB+1)-1:0] ret_cnt,
  output logic [NB-1:0]     bank_req,
  output logic [ADDR_W-1:0] bank_addr
);
  localparam int BIX_W = $clog2(NB);
  localparam int CNT_W = $clog2(NB + 1);

  logic [CNT_W-1:0] iss_q, iss_d;
  logic             iss_en;
  logic             gate;
  logic             can_issue;

  generate
    if (SERIAL) begin : g_serial
      assign gate = (iss_q == ret_cnt);
    end else begin : g_overlap
      assign gate = 1'b1;
    end
  endgenerate

  assign can_issue = busy & (iss_q != CNT_W'(NB)) & gate;

  always_comb begin
    iss_en = start | can_issue;
    iss_d  = start ? '0 : iss_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      iss_q <= '0;
    else if (iss_en) iss_q <= iss_d;
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_req
      assign bank_req[b] = can_issue & (iss_q == CNT_W'(b));
    end
  endgenerate

  assign bank_addr = {blk, iss_q[BIX_W-1:0]};

  // R3: never more than one bank asked per cycle
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req));
  // R2: the cycle after acceptance asks bank 0
  a_r2_first_bank: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> bank_req[0]);
  // R4: no word returns before it was requested
  a_r4_ret_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    ret_cnt <= iss_q);

  generate
    if (SERIAL) begin : g_serial_chk
      // R6: a later bank is asked only right after a word came back
      a_r6_wait_return: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_req && !bank_req[0]) |-> ret_cnt != $past(ret_cnt));
    end
  endgenerate
endmodule

// File: rtl/fill_collect.sv
module fill_collect #(
  parameter int NB = 4,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               start,
  input  logic               ret_valid,
  input  logic [DW-1:0]      ret_data,
  output logic [$clog2(NB+1)-1:0] ret_cnt,
  output logic               last_cap,
  output logic [NB*DW-1:0]   blk_data
);
  localparam int CNT_W = $clog2(NB + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cap;

  assign cap      = busy & ret_valid & (cnt_q != CNT_W'(NB));
  assign last_cap = cap & (cnt_q == CNT_W'(NB - 1));

  always_comb begin
    cnt_en = start | cap;
    cnt_d  = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    for (genvar w = 0; w < NB; w++) begin : g_word
      logic [DW-1:0] word_q;
      logic          word_en;
      assign word_en = cap & (cnt_q == CNT_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (word_en) word_q <= ret_data;
      end
      assign blk_data[w*DW +: DW] = word_q;
    end
  endgenerate

  assign ret_cnt = cnt_q;

  // R9: an idle engine keeps its buffer
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(blk_data));
  // R4: the word count never passes the block size
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NB));
endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int BANK_LAT  = 15,
  parameter bit SERIAL    = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fill_req,
  input  logic [ADDR_W-$clog2(NUM_BANKS)-1:0] fill_blk,
  output logic [NUM_BANKS-1:0]          bank_req,
  output logic [ADDR_W-1:0]             bank_addr,
  input  logic                          ret_valid,
  input  logic [DATA_W-1:0]             ret_data,
  output logic [NUM_BANKS*DATA_W-1:0]   blk_data,
  output logic                          fill_done
);
  localparam int BIX_W = $clog2(NUM_BANKS);
  localparam int BLK_W = ADDR_W - BIX_W;
  localparam int CNT_W = $clog2(NUM_BANKS + 1);

  logic             busy, start, last_cap;
  logic [BLK_W-1:0] blk;
  logic [CNT_W-1:0] ret_cnt;

  fill_ctrl #(.NB(NUM_BANKS), .BLK_W(BLK_W), .LAT(BANK_LAT), .SERIAL(SERIAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_blk(fill_blk),
    .last_cap(last_cap), .busy(busy), .start(start), .blk(blk), .done(fill_done)
  );

  fill_issue #(.NB(NUM_BANKS), .BLK_W(BLK_W), .ADDR_W(ADDR_W), .SERIAL(SERIAL)) u_issue (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .blk(blk),
    .ret_cnt(ret_cnt), .bank_req(bank_req), .bank_addr(bank_addr)
  );

  fill_collect #(.NB(NUM_BANKS), .DW(DATA_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start),
    .ret_valid(ret_valid), .ret_data(ret_data), .ret_cnt(ret_cnt),
    .last_cap(last_cap), .blk_data(blk_data)
  );
endmodule

// File: tb/sim_fill_engine.sv
module sim_fill_engine;
  localparam int NB = 4, AW = 16, DW = 32, LAT = 15;
  localparam int BW = AW - 2;
  localparam int PER = LAT + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           fq [2];
  logic [BW-1:0]  fb [2];
  logic [NB-1:0]  brq [2];
  logic [AW-1:0]  ba [2];
  logic           rv [2];
  logic [DW-1:0]  rd [2];
  logic [NB*DW-1:0] bd [2];
  logic           dn [2];

  fill_engine #(.NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW), .BANK_LAT(LAT), .SERIAL(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .fill_req(fq[0]), .fill_blk(fb[0]), .bank_req(brq[0]),
    .bank_addr(ba[0]), .ret_valid(rv[0]), .ret_data(rd[0]), .blk_data(bd[0]), .fill_done(dn[0]));
  fill_engine #(.NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW), .BANK_LAT(LAT), .SERIAL(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .fill_req(fq[1]), .fill_blk(fb[1]), .bank_req(brq[1]),
    .bank_addr(ba[1]), .ret_valid(rv[1]), .ret_data(rd[1]), .blk_data(bd[1]), .fill_done(dn[1]));

  int checks = 0, fails = 0, gc = 0;
  bit act [2];
  int rc [2], fidx [2], idle [2];
  logic [BW-1:0] cur [2];
  logic [NB*DW-1:0] eblk [2];
  int pend_t [2][NB];
  logic [AW-1:0] pend_a [2][NB];

  function automatic logic [DW-1:0] bank_word(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  function automatic logic [NB*DW-1:0] block_of(input logic [BW-1:0] b);
    logic [NB*DW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*DW +: DW] = bank_word({b, 2'(i)});
    return r;
  endfunction

  function automatic logic [BW-1:0] script_blk(input int i);
    case (i)
      0: return 14'h0123;
      1: return 14'h3FFF;
      2: return 14'h0000;
      default: return 14'h2A5C;
    endcase
  endfunction

  function automatic int fill_len(input int d);
    return (d == 1) ? NB * PER : NB + LAT + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NB*DW-1:0] a, input logic [NB*DW-1:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s gc=%0d act=%h exp=%h", tag, gc, a, e);
    end
  endtask

  always @(negedge clk) begin
    logic [NB-1:0] xr;
    logic [AW-1:0] xa;
    logic xd;
    bit acc;
    if (rst_n) begin
      gc++;
      for (int d = 0; d < 2; d++) begin
        if (act[d]) rc[d]++;
        xr = '0; xa = '0; xd = 1'b0;
        if (act[d] && rc[d] >= 0) begin
          if (d == 0) begin
            if (rc[d] < NB) begin xr[rc[d]] = 1'b1; xa = {cur[d], 2'(rc[d])}; end
          end else if ((rc[d] % PER) == 0 && rc[d] < NB * PER) begin
            xr[rc[d] / PER] = 1'b1; xa = {cur[d], 2'(rc[d] / PER)};
          end
          if (rc[d] == fill_len(d)) begin xd = 1'b1; eblk[d] = block_of(cur[d]); end
        end
        // R3 (overlapped cadence) and R6 (serial cadence), incl. R8 no extra requests
        chk(brq[d] === xr, (d == 0) ? "R3 bank_req" : "R6 bank_req", NB*DW'(brq[d]), NB*DW'(xr));
        if (|xr) chk(ba[d] === xa, "R2 bank_addr", NB*DW'(ba[d]), NB*DW'(xa));
        // R5 / R6 done cycle, R7 single pulse
        chk(dn[d] === xd, (d == 0) ? "R5 R7 fill_done" : "R6 R7 fill_done",
            NB*DW'(dn[d]), NB*DW'(xd));
        // R4 buffer contents, R9 unchanged by idle strobes
        if (!act[d] || rc[d] == fill_len(d))
          chk(bd[d] === eblk[d], "R4 R9 blk_data", bd[d], eblk[d]);

        for (int k = 0; k < NB; k++)
          if (brq[d][k]) begin pend_t[d][k] = gc + LAT + 1; pend_a[d][k] = ba[d]; end

        rv[d] = 1'b0; rd[d] = '0; fq[d] = 1'b0;
        for (int k = 0; k < NB; k++)
          if (pend_t[d][k] == gc) begin rv[d] = 1'b1; rd[d] = bank_word(pend_a[d][k]); end

        if (!act[d]) idle[d]++; else idle[d] = 0;
        if (!act[d] && idle[d] == 3 && !rv[d]) begin   // R9 stray strobe
          rv[d] = 1'b1; rd[d] = 32'hBAD0_BAD0;
        end
        if (act[d] && rc[d] == 3) begin                 // R8 request during a fill
          fq[d] = 1'b1; fb[d] = 14'h1555;
        end
        acc = !act[d] || rc[d] == fill_len(d);
        if (fidx[d] < 4 && acc &&
            ((fidx[d] == 2 && act[d]) || (!act[d] && idle[d] >= 6))) begin
          fq[d] = 1'b1; fb[d] = script_blk(fidx[d]); cur[d] = fb[d];
          fidx[d]++; act[d] = 1'b1; rc[d] = -1;         // R7 accept in done cycle when fidx==2
        end else if (act[d] && rc[d] == fill_len(d)) begin
          act[d] = 1'b0;
        end
      end
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      fq[d] = 1'b0; fb[d] = '0; rv[d] = 1'b0; rd[d] = '0;
      act[d] = 1'b0; rc[d] = 0; fidx[d] = 0; idle[d] = 0; cur[d] = '0; eblk[d] = '0;
      for (int k = 0; k < NB; k++) begin pend_t[d][k] = -1; pend_a[d][k] = '0; end
    end
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin   // R1 reset state
      chk(bd[d] === '0, "R1 blk_data", bd[d], '0);
      chk(dn[d] === 1'b0, "R1 fill_done", NB*DW'(dn[d]), '0);
      chk(brq[d] === '0, "R1 bank_req", NB*DW'(brq[d]), '0);
    end
    #1 rst_n = 1'b1;
    while (!(fidx[0] == 4 && !act[0] && idle[0] > 10 &&
             fidx[1] == 4 && !act[1] && idle[1] > 10)) begin
      @(posedge clk);
      if (gc > 3000) begin
        fails++;
        $display("FAIL R5 watchdog gc=%0d act=%0d exp=%0d", gc, fidx[0] + fidx[1], 8);
        break;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule